// File: doc/BRIEF.md
# Tick-Driven Timer Bank

The block holds sixteen countdown timers that all advance on one shared tick. A divider turns the system clock into that tick, and a 6-bit prescale setting picks its period. A host sets up one timer at a time. It first writes a command word that names the timer, says whether to enable or disable it, picks one-shot or auto-restart, and gives a timeout in ticks. It then writes a separate "go" register, which applies the command word to that timer.

On every tick, each enabled timer counts down by one. When a timer runs out, it sets its bit in an event register. Software clears that register by writing ones to the bits it wants cleared. A mask register chooses which event bits drive the single interrupt output. A free-running counter records how many ticks have occurred.

A usual setup keeps the tick-enable bit clear, programs every timer, and then sets tick-enable. All timers then start counting in step.

Top module: `tick_timer_bank`

## Requirements
- R1: There are 16 timers, numbered 0 to 15, and each one runs on its own. Timer n only ever sets bit n of the event register (address 3, bits 15:0), and timers with different timeouts expire on their own tick counts.
- R2: The command word sits at address 1, with the timeout in bits 15:0, the timer number in bits 19:16, the enable flag in bit 24 and the restart flag in bit 25. Any write to address 2 applies that word to the named timer. An enable command loads the timeout, and the timer expires on the timeout-th tick after the command. A timeout of 0 behaves like 1.
- R3: A disable command stops the named timer, and the timer sets no further events. Every field of the command word other than the timer number has no effect on a disable.
- R4: A one-shot timer (restart flag 0) sets its event once on expiry and then disables itself. It sets no further events until it receives another enable command.
- R5: A restart timer (restart flag 1) reloads its timeout on expiry and expires again every timeout ticks.
- R6: The configuration register is at address 0, with the prescale value in bits 5:0. One tick lasts prescale × TICK_UNIT system clocks, and TICK_UNIT defaults to 1024, so the value 63 gives 64,512 clocks. A prescale value of 0 produces no ticks.
- R7: The tick-enable bit is bit 8 of address 0. While it is clear there are no ticks and the divider stays at its start. After the write that sets it, the first tick comes one full tick period later.
- R8: The tick counter is at address 5, bits 15:0. It adds one on each tick, and any write to address 5 clears it.
- R9: Writing a 1 to a bit of address 3 clears that event bit, and writing a 0 leaves the bit unchanged. If a timer expires in the same cycle that its bit is cleared, the bit stays set.
- R10: The mask register is at address 4, bits 15:0. `irq` is high exactly when some event bit and its mask bit are both 1.
- R11: After reset, all timers are disabled, and the event register, mask, tick counter and configuration all read 0. `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address (used for both writes and reads) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Masked OR of the event bits |

## Verification
The bench samples the event register one clock before the expected expiry edge and again on that edge. An off-by-one in the countdown, or in the divider's reload, therefore shows up as an early or a late event. It times a write-one-to-clear to land on a clock edge with no tick, and another to land on an expiry edge. A design where the clear takes priority over the set would lose the second event.

The bench issues a disable command whose other fields carry a live timeout and the restart flag. A design that acts on those fields would keep the timer firing. It also checks that a one-shot timer stays silent after its first event, that a prescale of 0 and a cleared tick-enable both freeze the tick counter, and that the interrupt follows the mask.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  parameter int NUM_TIMERS = 16;
  parameter int PERIOD_W   = 16;
  parameter int PRESCALE_W = 6;
  parameter int CNT_W      = 16;
  parameter int ADDR_W     = 3;
  parameter int DATA_W     = 32;
  localparam int IDX_W     = $clog2(NUM_TIMERS);

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_GO   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_EVT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd5;

  // Strobes and settings passed from control to datapath
  typedef struct packed {
    logic                  cmdGo;
    logic                  cmdEnable;
    logic                  cmdRestart;
    logic [IDX_W-1:0]      cmdIdx;
    logic [PERIOD_W-1:0]   cmdPeriod;
    logic [NUM_TIMERS-1:0] evtClr;
    logic                  cntClr;
    logic                  tickEn;
    logic [PRESCALE_W-1:0] prescale;
    logic [NUM_TIMERS-1:0] maskVal;
  } ctlBus_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_TIMERS-1:0] evtBits,
  input  logic [CNT_W-1:0]      tickCount,
  output ctlBus_t               ctl,
  output logic [DATA_W-1:0]     rdData
);
  logic [PRESCALE_W-1:0] cfgPrescale;
  logic                  cfgTickEn;
  logic [PERIOD_W-1:0]   cmdPeriod;
  logic [IDX_W-1:0]      cmdIdx;
  logic                  cmdEnable, cmdRestart;
  logic [NUM_TIMERS-1:0] maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPrescale <= '0;
      cfgTickEn   <= 1'b0;
      cmdPeriod   <= '0;
      cmdIdx      <= '0;
      cmdEnable   <= 1'b0;
      cmdRestart  <= 1'b0;
      maskReg     <= '0;
    end else if (wrEn) begin
      case (addr)
        ADDR_CFG: begin
          cfgPrescale <= wrData[PRESCALE_W-1:0];
          cfgTickEn   <= wrData[8];
        end
        ADDR_CMD: begin
          cmdPeriod  <= wrData[PERIOD_W-1:0];
          cmdIdx     <= wrData[16 +: IDX_W];
          cmdEnable  <= wrData[24];
          cmdRestart <= wrData[25];
        end
        ADDR_MASK: maskReg <= wrData[NUM_TIMERS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.cmdGo      = wrEn && (addr == ADDR_GO);
    ctl.cmdEnable  = cmdEnable;
    ctl.cmdRestart = cmdRestart;
    ctl.cmdIdx     = cmdIdx;
    ctl.cmdPeriod  = cmdPeriod;
    ctl.evtClr     = (wrEn && addr == ADDR_EVT) ? wrData[NUM_TIMERS-1:0] : '0;
    ctl.cntClr     = wrEn && (addr == ADDR_CNT);
    ctl.tickEn     = cfgTickEn;
    ctl.prescale   = cfgPrescale;
    ctl.maskVal    = maskReg;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CFG: begin
        rdData[PRESCALE_W-1:0] = cfgPrescale;
        rdData[8]              = cfgTickEn;
      end
      ADDR_CMD: begin
        rdData[PERIOD_W-1:0] = cmdPeriod;
        rdData[16 +: IDX_W]  = cmdIdx;
        rdData[24]           = cmdEnable;
        rdData[25]           = cmdRestart;
      end
      ADDR_EVT:  rdData[NUM_TIMERS-1:0] = evtBits;
      ADDR_MASK: rdData[NUM_TIMERS-1:0] = maskReg;
      ADDR_CNT:  rdData[CNT_W-1:0]      = tickCount;
      default: ;
    endcase
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int TICK_UNIT = 1024
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlBus_t               ctl,
  output logic [NUM_TIMERS-1:0] evtBits,
  output logic [CNT_W-1:0]      tickCount,
  output logic                  irq
);
  localparam int MAX_DIV = TICK_UNIT * ((1 << PRESCALE_W) - 1);
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] divCnt, divLimit;
  logic run, tick;

  always_comb begin
    divLimit = DIV_W'(32'(ctl.prescale) * TICK_UNIT - 1);
    run      = ctl.tickEn && (ctl.prescale != '0);
    tick     = run && (divCnt >= divLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (!run) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           tickCount <= '0;
    else if (ctl.cntClr) tickCount <= '0;
    else if (tick)       tickCount <= tickCount + 1'b1;
  end

  // R8
  tick_count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !ctl.cntClr) |=> (tickCount == $past(tickCount) + 1'b1));
  // R7
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.tickEn && !ctl.cntClr) |=> $stable(tickCount));

  logic [NUM_TIMERS-1:0] active, restart, setEvt;
  logic [PERIOD_W-1:0]   reload [NUM_TIMERS];
  logic [PERIOD_W-1:0]   remain [NUM_TIMERS];

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : gTimer
    logic hit;
    assign hit       = ctl.cmdGo && (ctl.cmdIdx == IDX_W'(g));
    assign setEvt[g] = !hit && tick && active[g] && (remain[g] <= 1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        active[g]  <= 1'b0;
        restart[g] <= 1'b0;
        reload[g]  <= '0;
        remain[g]  <= '0;
      end else if (hit) begin
        active[g] <= ctl.cmdEnable;
        if (ctl.cmdEnable) begin
          restart[g] <= ctl.cmdRestart;
          reload[g]  <= ctl.cmdPeriod;
          remain[g]  <= ctl.cmdPeriod;
        end
      end else if (tick && active[g]) begin
        if (remain[g] <= 1) begin
          if (restart[g]) remain[g] <= reload[g];
          else            active[g] <= 1'b0;
        end else begin
          remain[g] <= remain[g] - 1'b1;
        end
      end
    end

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (setEvt[g] && !restart[g]) |=> !active[g]);
    // R5
    restart_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
      (setEvt[g] && restart[g]) |=> (active[g] && remain[g] == reload[g]));
    // R9
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.evtClr[g] && !setEvt[g]) |=> !evtBits[g]);
    // R9
    evt_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      setEvt[g] |=> evtBits[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtBits <= '0;
    else       evtBits <= (evtBits & ~ctl.evtClr) | setEvt;
  end

  assign irq = |(evtBits & ctl.maskVal);
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int TICK_UNIT = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  ctlBus_t               ctl;
  logic [NUM_TIMERS-1:0] evtBits;
  logic [CNT_W-1:0]      tickCount;

  tick_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .evtBits(evtBits), .tickCount(tickCount), .ctl(ctl), .rdData(rdData)
  );

  tick_timer_dp #(.TICK_UNIT(TICK_UNIT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .evtBits(evtBits), .tickCount(tickCount), .irq(irq)
  );

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.maskVal == '0) |-> !irq);
endmodule

// File: tb/tick_timer_bank_tb.sv
`timescale 1ns/1ps
module tick_timer_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;
  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  tick_timer_bank #(.TICK_UNIT(2)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  idx;
    logic [15:0] period;
    logic        rst;
    logic [15:0] waitCyc;
    logic [15:0] expEvt;
  } vec_t;

  // prescale 1, TICK_UNIT 2: tick k lands on clock edge 2k after tick-enable
  localparam vec_t VECS [8] = '{
    '{4'd0,  16'd3,  1'b0, 16'd5,  16'h0000},  // R2 one edge early
    '{4'd0,  16'd3,  1'b0, 16'd6,  16'h0001},  // R2 on time
    '{4'd15, 16'd1,  1'b0, 16'd2,  16'h8000},  // R1 top timer
    '{4'd15, 16'd1,  1'b0, 16'd1,  16'h0000},  // R2
    '{4'd7,  16'd0,  1'b0, 16'd2,  16'h0080},  // R2 zero acts as one
    '{4'd4,  16'd2,  1'b1, 16'd12, 16'h0010},  // R5
    '{4'd9,  16'd10, 1'b1, 16'd20, 16'h0200},  // R5 long
    '{4'd9,  16'd10, 1'b1, 16'd19, 16'h0000}   // R5 early
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cmdWord(input int idx, input int per, input bit en, input bit rs);
    return {6'b0, rs, en, 4'b0, 4'(idx), 16'(per)};
  endfunction

  task automatic startTimer(input int idx, input int per, input bit rs);
    wr(3'd1, cmdWord(idx, per, 1'b1, rs));
    wr(3'd2, 32'd0);
  endtask

  task automatic stopTimer(input int idx);
    wr(3'd1, cmdWord(idx, 0, 1'b0, 1'b0));
    wr(3'd2, 32'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(2);
    rstN = 1'b1;
    idle(1);

    // R11 reset state
    rd(3'd3, v); check("R11 evt", v, 0);
    rd(3'd5, v); check("R11 cnt", v, 0);
    rd(3'd0, v); check("R11 cfg", v, 0);
    check("R11 irq", {31'b0, irq}, 0);

    foreach (VECS[i]) begin
      wr(3'd0, 32'h0000_0001);
      wr(3'd3, 32'hFFFF);
      startTimer(VECS[i].idx, VECS[i].period, VECS[i].rst);
      wr(3'd0, 32'h0000_0101);
      idle(VECS[i].waitCyc);
      rd(3'd3, v);
      check($sformatf("R2 vector %0d", i), v, {16'b0, VECS[i].expEvt});
      wr(3'd0, 32'h0000_0001);
      stopTimer(VECS[i].idx);
    end
    wr(3'd3, 32'hFFFF);

    // R1 two timers independent
    startTimer(10, 2, 1'b0);
    startTimer(11, 4, 1'b0);
    wr(3'd0, 32'h101);
    idle(4); rd(3'd3, v); check("R1 first", v, 32'h0400);
    idle(4); rd(3'd3, v); check("R1 second", v, 32'h0C00);
    wr(3'd0, 32'h001); wr(3'd3, 32'hFFFF);

    // R4 one-shot fires once
    startTimer(2, 2, 1'b0);
    wr(3'd0, 32'h101);
    idle(4); rd(3'd3, v); check("R4 fired", v, 32'h0004);
    wr(3'd3, 32'h0004);
    idle(12); rd(3'd3, v); check("R4 no refire", v, 0);
    wr(3'd0, 32'h001);

    // R5 restart refires; clear on a non-tick edge
    startTimer(3, 2, 1'b1);
    wr(3'd0, 32'h101);
    idle(4); rd(3'd3, v); check("R5 first", v, 32'h0008);
    wr(3'd3, 32'h0008); rd(3'd3, v); check("R9 cleared", v, 0);
    idle(3); rd(3'd3, v); check("R5 refire", v, 32'h0008);
    wr(3'd0, 32'h001); stopTimer(3); wr(3'd3, 32'hFFFF);

    // R9 write of zeros leaves bits; set wins over same-cycle clear
    startTimer(1, 1, 1'b1);
    wr(3'd0, 32'h101);
    idle(4);
    wr(3'd3, 32'h0000); rd(3'd3, v); check("R9 zero write", v, 32'h0002);
    wr(3'd3, 32'h0002); rd(3'd3, v); check("R9 set wins", v, 32'h0002);
    wr(3'd0, 32'h001);

    // R10 mask gating
    check("R10 masked off", {31'b0, irq}, 0);
    wr(3'd4, 32'h0001); check("R10 other bit", {31'b0, irq}, 0);
    wr(3'd4, 32'h0002); check("R10 enabled", {31'b0, irq}, 1);
    wr(3'd3, 32'h0002); check("R10 after clear", {31'b0, irq}, 0);
    wr(3'd4, 32'h0000);
    stopTimer(1);

    // R3 disable ignores other fields
    startTimer(5, 4, 1'b1);
    wr(3'd1, cmdWord(5, 1, 1'b0, 1'b1));
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h101);
    idle(20); rd(3'd3, v); check("R3 disabled", v, 0);
    wr(3'd0, 32'h001);

    // R6 prescale 3 -> 6 clocks per tick
    wr(3'd5, 32'd0);
    startTimer(6, 1, 1'b0);
    wr(3'd0, 32'h103);
    idle(5); rd(3'd3, v); check("R6 early", v, 0);
    idle(1); rd(3'd3, v); check("R6 on time", v, 32'h0040);
    rd(3'd5, v); check("R8 one tick", v, 1);
    wr(3'd0, 32'h003); wr(3'd3, 32'hFFFF);

    // R6 prescale 0 gives no ticks
    wr(3'd5, 32'd0);
    wr(3'd0, 32'h100);
    idle(40); rd(3'd5, v); check("R6 zero prescale", v, 0);

    // R7 / R8 tick counting, halt, clear
    wr(3'd0, 32'h101);
    idle(10); rd(3'd5, v); check("R8 count", v, 5);
    wr(3'd0, 32'h001);
    idle(20); rd(3'd5, v); check("R7 halted", v, 5);
    wr(3'd5, 32'd0); rd(3'd5, v); check("R8 clear", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule